// File: doc/BRIEF.md
# Sector Address Sequencer and Checker

This block runs once before each sector of a multi-sector disk read or write. A command start loads the cylinder, head, sector and transfer direction. Each sector request is then checked against whether a drive is present, whether it is write protected, and the drive geometry (cylinder limit and surface count, 64 sectors per track). The outcome is reported as a single-cycle completion pulse together with one-hot error flags. A good check also yields the linear sector address and moves the sector and head forward for the next sector. Address faults set sticky drive status flags.

A second unit fills out each sector's byte stream to the full 256 bytes. When the data source ends early, a write sector is filled by repeating the last byte received, and a read sector is filled with zeros.

The checker is a three-state machine. CK_IDLE moves to CK_EVAL on `chk_req`. CK_EVAL always moves to CK_REPORT, which registers the result. CK_REPORT always returns to CK_IDLE, and `chk_done` is high in that state. The pad unit also has three states. PD_IDLE moves to PD_PASS on `pad_begin`. PD_PASS returns to PD_IDLE when the 256th byte has been accepted, or moves to PD_FILL when `pad_in_last` arrives earlier. PD_FILL returns to PD_IDLE after emitting the 256th byte.

Top module: `secseq_top`

## Requirements
- R1: After reset, `chk_done`, `chk_err`, `addr_valid`, `lin_addr`, `drv_seek_inc`, `drv_unsafe`, `pad_out_valid` and `pad_out_end` are all 0.
- R2: For a good check, `lin_addr` = ((cylinder × surfaces) + head) × 64 + sector, and `addr_valid` is 1 together with `chk_done`. Whenever an error is flagged, `addr_valid` and `lin_addr` are 0.
- R3: If `drv_present` is 0, the check ends with the transfer-error flag `chk_err[0]`. This has the highest priority.
- R4: A write command to a drive with `drv_wprot` = 1 ends with the write-protect flag `chk_err[1]`. A read from a protected drive is not affected.
- R5: A cylinder greater than or equal to `geo_cyls` ends with `chk_err[0]` and sets the sticky flag `drv_seek_inc`.
- R6: A head greater than or equal to `geo_surf` on the first sector ends with address-compare fail `chk_err[2]` and sets the sticky flag `drv_unsafe`. On a later sector it ends with cylinder overflow `chk_err[3]` and leaves `drv_unsafe` unchanged.
- R7: The sector number is the low 6 bits of the 8-bit `sec_reg_in`. After each good check the sector increments modulo 64, and on a wrap to 0 the head increments by one. `cur_sector` and `cur_head` show the values for the next sector.
- R8: `cmd_start` marks the next sector as the first. A good check clears that mark. A failed check leaves it set.
- R9: A write sector whose data ends (`pad_in_last`) before 256 bytes is completed by repeating the last byte received, up to 256 bytes in total.
- R10: A read sector that ends early is completed with zero bytes, up to 256 bytes in total.
- R11: Every sector emits exactly 256 bytes. `pad_out_end` is high with the 256th byte only. A full 256-byte input is passed through unchanged.
- R12: `chk_err` has at most one bit set. It is nonzero only while `chk_done` is high, and `chk_done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Load a new command (taken only in CK_IDLE) |
| cmd_write | input | 1 | Command is a write |
| cyl_in | input | CYL_W | Starting cylinder |
| head_in | input | HEAD_W | Starting head |
| sec_reg_in | input | 8 | Sector register; the low 6 bits are used |
| drv_present | input | 1 | Drive is present |
| drv_wprot | input | 1 | Drive is write protected |
| geo_cyls | input | CYL_W+1 | Number of cylinders on the drive |
| geo_surf | input | HEAD_W+1 | Number of surfaces on the drive |
| chk_req | input | 1 | Check the next sector (taken only in CK_IDLE) |
| chk_done | output | 1 | One-cycle completion pulse |
| chk_err | output | 4 | One-hot error: [0] transfer, [1] write protect, [2] address compare, [3] cylinder overflow |
| addr_valid | output | 1 | Linear address is valid |
| lin_addr | output | CYL_W+HEAD_W+7 | Linear sector address |
| cur_sector | output | 6 | Sector for the next check |
| cur_head | output | HEAD_W | Head for the next check |
| drv_seek_inc | output | 1 | Sticky seek-incomplete status |
| drv_unsafe | output | 1 | Sticky unsafe status |
| pad_begin | input | 1 | Start a sector byte stream; fill mode follows the loaded command |
| pad_in_valid | input | 1 | Input byte valid |
| pad_in_byte | input | 8 | Input byte |
| pad_in_last | input | 1 | Last supplied byte of this sector |
| pad_out_valid | output | 1 | Output byte valid |
| pad_out_byte | output | 8 | Output byte |
| pad_out_end | output | 1 | 256th byte of the sector |

## Verification
`chk_req` is sampled at one rising edge, and the result registers load at the next edge. So `chk_done`, `chk_err`, `addr_valid`, `lin_addr` and the advanced `cur_sector`/`cur_head` are checked at the falling edge after that second edge. `chk_done` is checked low again one cycle later. The sticky drive flags are read at that same falling edge.

Pad output follows each accepted input byte by one edge, and fill bytes follow one per cycle. The bench therefore gathers the stream at every falling edge and compares the whole sector, and the position of `pad_out_end`, only after the end marker has appeared.

// File: rtl/secseq_pkg.sv
package secseq_pkg;
    localparam int SEC_W     = 6;
    localparam int ERR_N     = 4;
    localparam int ERR_XFER  = 0;
    localparam int ERR_WPROT = 1;
    localparam int ERR_ACF   = 2;
    localparam int ERR_CYO   = 3;

    typedef enum logic [1:0] {CK_IDLE, CK_EVAL, CK_REPORT} ck_state_t;
    typedef enum logic [1:0] {PD_IDLE, PD_PASS, PD_FILL} pd_state_t;
endpackage

// File: rtl/secseq_check.sv
module secseq_check
    import secseq_pkg::*;
#(
    parameter int CYL_W  = 12,
    parameter int HEAD_W = 5,
    localparam int ADDR_W = CYL_W + HEAD_W + 1 + SEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_write,
    input  logic [CYL_W-1:0]  cyl_in,
    input  logic [HEAD_W-1:0] head_in,
    input  logic [SEC_W-1:0]  sec_in,
    input  logic              drv_present,
    input  logic              drv_wprot,
    input  logic [CYL_W:0]    geo_cyls,
    input  logic [HEAD_W:0]   geo_surf,
    input  logic              chk_req,
    output logic              done,
    output logic [ERR_N-1:0]  err,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] lin_addr,
    output logic [SEC_W-1:0]  cur_sector,
    output logic [HEAD_W-1:0] cur_head,
    output logic              wr_mode,
    output logic              seek_inc,
    output logic              unsafe
);
    ck_state_t state_q, state_d;

    logic [CYL_W-1:0]  cyl_q;
    logic [HEAD_W-1:0] head_q;
    logic [SEC_W-1:0]  sec_q;
    logic              first_q, wr_q;
    logic [ERR_N-1:0]  err_d;
    logic              bad_cyl, bad_head_first;
    logic [ADDR_W-1:0] addr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_IDLE:   if (chk_req) state_d = CK_EVAL;
            CK_EVAL:   state_d = CK_REPORT;
            CK_REPORT: state_d = CK_IDLE;
            default:   state_d = CK_IDLE;
        endcase
    end

    always_comb begin
        err_d          = '0;
        bad_cyl        = 1'b0;
        bad_head_first = 1'b0;
        if (!drv_present) begin
            err_d[ERR_XFER] = 1'b1;
        end else if (wr_q && drv_wprot) begin
            err_d[ERR_WPROT] = 1'b1;
        end else if ({1'b0, cyl_q} >= geo_cyls) begin
            err_d[ERR_XFER] = 1'b1;
            bad_cyl         = 1'b1;
        end else if ({1'b0, head_q} >= geo_surf) begin
            if (first_q) begin
                err_d[ERR_ACF] = 1'b1;
                bad_head_first = 1'b1;
            end else begin
                err_d[ERR_CYO] = 1'b1;
            end
        end
        addr_d = ((ADDR_W'(cyl_q) * ADDR_W'(geo_surf) + ADDR_W'(head_q)) << SEC_W)
                 | ADDR_W'(sec_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyl_q <= '0; head_q <= '0; sec_q <= '0;
            first_q <= 1'b0; wr_q <= 1'b0;
            done <= 1'b0; err <= '0; addr_valid <= 1'b0; lin_addr <= '0;
            seek_inc <= 1'b0; unsafe <= 1'b0;
        end else begin
            done       <= 1'b0;
            err        <= '0;
            addr_valid <= 1'b0;
            lin_addr   <= '0;
            if (state_q == CK_IDLE && cmd_start) begin
                cyl_q   <= cyl_in;
                head_q  <= head_in;
                sec_q   <= sec_in;
                wr_q    <= cmd_write;
                first_q <= 1'b1;
            end
            if (state_q == CK_EVAL) begin
                done <= 1'b1;
                err  <= err_d;
                if (err_d == '0) begin
                    addr_valid <= 1'b1;
                    lin_addr   <= addr_d;
                    sec_q      <= sec_q + 1'b1;
                    if (sec_q == '1) head_q <= head_q + 1'b1;
                    first_q    <= 1'b0;
                end
                if (bad_cyl)        seek_inc <= 1'b1;
                if (bad_head_first) unsafe   <= 1'b1;
            end
        end
    end

    assign cur_sector = sec_q;
    assign cur_head   = head_q;
    assign wr_mode    = wr_q;

    p_err_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err));
    p_err_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (err != '0) |-> done);
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_valid_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (done && err == '0));
    p_sec_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (sec_q == $past(sec_q) + 1'b1));
    p_first_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> !first_q);
    p_unsafe_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unsafe) |-> err[ERR_ACF]);
    p_seek_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seek_inc) |-> err[ERR_XFER]);
endmodule

// File: rtl/secseq_pad.sv
module secseq_pad
    import secseq_pkg::*;
#(
    parameter int SECT_BYTES = 256,
    localparam int IDX_W = $clog2(SECT_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       begin_sect,
    input  logic       fill_last,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_last,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_end
);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(SECT_BYTES - 1);

    pd_state_t        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       last_q;
    logic             mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE: if (begin_sect) state_d = PD_PASS;
            PD_PASS: if (in_valid) begin
                         if (idx_q == IDX_MAX) state_d = PD_IDLE;
                         else if (in_last)     state_d = PD_FILL;
                     end
            PD_FILL: if (idx_q == IDX_MAX) state_d = PD_IDLE;
            default: state_d = PD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0; last_q <= '0; mode_q <= 1'b0;
            out_valid <= 1'b0; out_byte <= '0; out_end <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_end   <= 1'b0;
            unique case (state_q)
                PD_IDLE: if (begin_sect) begin
                    idx_q  <= '0;
                    last_q <= '0;
                    mode_q <= fill_last;
                end
                PD_PASS: if (in_valid) begin
                    out_valid <= 1'b1;
                    out_byte  <= in_byte;
                    last_q    <= in_byte;
                    out_end   <= (idx_q == IDX_MAX);
                    idx_q     <= idx_q + 1'b1;
                end
                PD_FILL: begin
                    out_valid <= 1'b1;
                    out_byte  <= mode_q ? last_q : 8'h00;
                    out_end   <= (idx_q == IDX_MAX);
                    idx_q     <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    p_end_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_end |-> out_valid);
    p_fill_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_FILL && mode_q) |=> (out_byte == $past(last_q)));
    p_fill_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_FILL && !mode_q) |=> (out_byte == 8'h00));
endmodule

// File: rtl/secseq_top.sv
module secseq_top
    import secseq_pkg::*;
#(
    parameter int CYL_W  = 12,
    parameter int HEAD_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_start,
    input  logic                          cmd_write,
    input  logic [CYL_W-1:0]              cyl_in,
    input  logic [HEAD_W-1:0]             head_in,
    input  logic [7:0]                    sec_reg_in,
    input  logic                          drv_present,
    input  logic                          drv_wprot,
    input  logic [CYL_W:0]                geo_cyls,
    input  logic [HEAD_W:0]               geo_surf,
    input  logic                          chk_req,
    output logic                          chk_done,
    output logic [3:0]                    chk_err,
    output logic                          addr_valid,
    output logic [CYL_W+HEAD_W+6:0]       lin_addr,
    output logic [5:0]                    cur_sector,
    output logic [HEAD_W-1:0]             cur_head,
    output logic                          drv_seek_inc,
    output logic                          drv_unsafe,
    input  logic                          pad_begin,
    input  logic                          pad_in_valid,
    input  logic [7:0]                    pad_in_byte,
    input  logic                          pad_in_last,
    output logic                          pad_out_valid,
    output logic [7:0]                    pad_out_byte,
    output logic                          pad_out_end
);
    logic wr_mode;

    secseq_check #(.CYL_W(CYL_W), .HEAD_W(HEAD_W)) u_check (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cyl_in(cyl_in), .head_in(head_in), .sec_in(sec_reg_in[SEC_W-1:0]),
        .drv_present(drv_present), .drv_wprot(drv_wprot),
        .geo_cyls(geo_cyls), .geo_surf(geo_surf),
        .chk_req(chk_req),
        .done(chk_done), .err(chk_err), .addr_valid(addr_valid), .lin_addr(lin_addr),
        .cur_sector(cur_sector), .cur_head(cur_head), .wr_mode(wr_mode),
        .seek_inc(drv_seek_inc), .unsafe(drv_unsafe)
    );

    secseq_pad #(.SECT_BYTES(256)) u_pad (
        .clk(clk), .rst_n(rst_n),
        .begin_sect(pad_begin), .fill_last(wr_mode),
        .in_valid(pad_in_valid), .in_byte(pad_in_byte), .in_last(pad_in_last),
        .out_valid(pad_out_valid), .out_byte(pad_out_byte), .out_end(pad_out_end)
    );
endmodule

// File: tb/secseq_top_tb_top.sv
module secseq_top_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cmd_start, cmd_write, drv_present, drv_wprot, chk_req;
    logic [11:0] cyl_in; logic [4:0] head_in; logic [7:0] sec_reg_in;
    logic [12:0] geo_cyls; logic [5:0] geo_surf;
    logic chk_done, addr_valid, drv_seek_inc, drv_unsafe;
    logic [3:0] chk_err; logic [23:0] lin_addr; logic [5:0] cur_sector; logic [4:0] cur_head;
    logic pad_begin, pad_in_valid, pad_in_last, pad_out_valid, pad_out_end;
    logic [7:0] pad_in_byte, pad_out_byte;

    secseq_top dut_i (.*);

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ck_eq(input string req, input longint act, input longint exp);
        check(act == exp, req, act, exp);
    endtask

    typedef struct packed {
        logic [11:0] cyl; logic [4:0] head; logic [7:0] sec;
        logic wr; logic pres; logic wp;
        logic [12:0] ncyl; logic [5:0] nsurf;
        logic [3:0] err; logic [23:0] addr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{12'd0,    5'd0,  8'h00, 1'b0, 1'b1, 1'b0, 13'd823,  6'd5,  4'b0000, 24'd0},       // R2
        '{12'd10,   5'd2,  8'h05, 1'b1, 1'b1, 1'b0, 13'd823,  6'd5,  4'b0000, 24'd3333},    // R2
        '{12'd822,  5'd4,  8'h3F, 1'b0, 1'b1, 1'b0, 13'd823,  6'd5,  4'b0000, 24'd263359},  // R2
        '{12'd1,    5'd0,  8'hC7, 1'b0, 1'b1, 1'b0, 13'd823,  6'd3,  4'b0000, 24'd199},     // R7 low 6 bits
        '{12'd0,    5'd0,  8'h00, 1'b0, 1'b0, 1'b0, 13'd823,  6'd5,  4'b0001, 24'd0},       // R3
        '{12'd0,    5'd0,  8'h00, 1'b1, 1'b0, 1'b1, 13'd823,  6'd5,  4'b0001, 24'd0},       // R3 priority
        '{12'd0,    5'd0,  8'h00, 1'b1, 1'b1, 1'b1, 13'd823,  6'd5,  4'b0010, 24'd0},       // R4
        '{12'd2,    5'd1,  8'h00, 1'b0, 1'b1, 1'b1, 13'd823,  6'd5,  4'b0000, 24'd704},     // R4 read ok
        '{12'd823,  5'd0,  8'h00, 1'b0, 1'b1, 1'b0, 13'd823,  6'd5,  4'b0001, 24'd0},       // R5
        '{12'd1024, 5'd0,  8'h00, 1'b0, 1'b1, 1'b0, 13'd1024, 6'd16, 4'b0001, 24'd0},       // R5
        '{12'd1023, 5'd15, 8'h01, 1'b0, 1'b1, 1'b0, 13'd1024, 6'd16, 4'b0000, 24'd1048513}, // R2
        '{12'd0,    5'd5,  8'h00, 1'b0, 1'b1, 1'b0, 13'd823,  6'd5,  4'b0100, 24'd0}        // R6
    };

    task automatic start_cmd(input logic [11:0] c, input logic [4:0] h, input logic [7:0] s, input logic w);
        @(negedge clk);
        cyl_in = c; head_in = h; sec_reg_in = s; cmd_write = w; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic do_check();
        @(negedge clk); chk_req = 1'b1;
        @(negedge clk); chk_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    logic [7:0] cap [256];
    int cap_n = 0, end_at = -1;
    always @(negedge clk) begin
        if (pad_out_valid) begin
            if (cap_n < 256) cap[cap_n] = pad_out_byte;
            cap_n++;
            if (pad_out_end) end_at = cap_n;
        end
    end

    task automatic pad_run(input logic wr, input int n, input string req);
        int bad = 0; int first_bad = -1; logic [7:0] expv;
        start_cmd(12'd0, 5'd0, 8'd0, wr);
        cap_n = 0; end_at = -1;
        @(negedge clk); pad_begin = 1'b1;
        @(negedge clk); pad_begin = 1'b0;
        for (int i = 0; i < n; i++) begin
            pad_in_valid = 1'b1; pad_in_byte = 8'(8'h40 + i); pad_in_last = (i == n - 1);
            @(negedge clk);
        end
        pad_in_valid = 1'b0; pad_in_last = 1'b0;
        for (int k = 0; k < 400 && end_at < 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        ck_eq({req, " byte count"}, cap_n, 256);
        ck_eq({req, " end position R11"}, end_at, 256);
        for (int i = 0; i < 256; i++) begin
            if (i < n) expv = 8'(8'h40 + i);
            else expv = wr ? 8'(8'h40 + n - 1) : 8'h00;
            if (cap[i] != expv) begin bad++; if (first_bad < 0) first_bad = i; end
        end
        ck_eq({req, " mismatched bytes"}, bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cmd_start = 0; cmd_write = 0; drv_present = 1; drv_wprot = 0; chk_req = 0;
        cyl_in = 0; head_in = 0; sec_reg_in = 0; geo_cyls = 13'd823; geo_surf = 6'd5;
        pad_begin = 0; pad_in_valid = 0; pad_in_byte = 0; pad_in_last = 0;
        do_reset();
        @(negedge clk);
        // R1 reset state
        ck_eq("R1 chk_done", chk_done, 0);
        ck_eq("R1 chk_err", chk_err, 0);
        ck_eq("R1 addr_valid", addr_valid, 0);
        ck_eq("R1 lin_addr", lin_addr, 0);
        ck_eq("R1 seek_inc", drv_seek_inc, 0);
        ck_eq("R1 unsafe", drv_unsafe, 0);
        ck_eq("R1 pad_out_valid", pad_out_valid, 0);
        ck_eq("R1 pad_out_end", pad_out_end, 0);

        // table walk: R2 R3 R4 R5 R6 R7 R12
        for (int v = 0; v < NV; v++) begin
            drv_present = TBL[v].pres; drv_wprot = TBL[v].wp;
            geo_cyls = TBL[v].ncyl; geo_surf = TBL[v].nsurf;
            start_cmd(TBL[v].cyl, TBL[v].head, TBL[v].sec, TBL[v].wr);
            do_check();
            ck_eq($sformatf("R12 vec%0d done", v), chk_done, 1);
            ck_eq($sformatf("R3/R4/R5/R6 vec%0d err", v), chk_err, TBL[v].err);
            ck_eq($sformatf("R2 vec%0d valid", v), addr_valid, TBL[v].err == 0);
            ck_eq($sformatf("R2 vec%0d addr", v), lin_addr, TBL[v].addr);
            @(negedge clk);
            ck_eq($sformatf("R12 vec%0d done one cycle", v), chk_done, 0);
            ck_eq($sformatf("R12 vec%0d err cleared", v), chk_err, 0);
        end

        // R5 sticky seek-incomplete
        do_reset();
        drv_present = 1; drv_wprot = 0; geo_cyls = 13'd823; geo_surf = 6'd2;
        start_cmd(12'd900, 5'd0, 8'd0, 1'b0);
        do_check();
        ck_eq("R5 seek_inc set", drv_seek_inc, 1);
        start_cmd(12'd3, 5'd0, 8'd0, 1'b0);
        do_check();
        ck_eq("R5 seek_inc sticky", drv_seek_inc, 1);
        ck_eq("R5 good check after", chk_err, 0);

        // R7 sector wrap and head advance across sectors
        do_reset();
        start_cmd(12'd3, 5'd0, 8'd62, 1'b0);
        do_check();
        ck_eq("R7 s62 addr", lin_addr, 446);
        ck_eq("R7 next sector 63", cur_sector, 63);
        ck_eq("R7 head still 0", cur_head, 0);
        do_check();
        ck_eq("R7 s63 addr", lin_addr, 447);
        ck_eq("R7 wrap sector 0", cur_sector, 0);
        ck_eq("R7 head advanced", cur_head, 1);
        do_check();
        ck_eq("R7 after wrap addr", lin_addr, 448);
        ck_eq("R7 sector 1", cur_sector, 1);

        // R6 / R8 later-sector head overflow -> cylinder overflow
        start_cmd(12'd3, 5'd1, 8'd63, 1'b0);
        do_check();
        ck_eq("R8 first sector good", lin_addr, 511);
        ck_eq("R7 head to 2", cur_head, 2);
        do_check();
        ck_eq("R6 later sector cyl ovf", chk_err, 4'b1000);
        ck_eq("R6 unsafe unchanged", drv_unsafe, 0);
        ck_eq("R2 no addr on error", addr_valid, 0);

        // R6 / R8 first sector head fault
        start_cmd(12'd3, 5'd2, 8'd0, 1'b0);
        do_check();
        ck_eq("R6 first sector acf", chk_err, 4'b0100);
        ck_eq("R6 unsafe set", drv_unsafe, 1);
        // R8 failed check keeps first-sector mark
        do_check();
        ck_eq("R8 still first after error", chk_err, 4'b0100);

        // R8 a failed first check, then good, then overflow as later sector
        geo_surf = 6'd3;
        start_cmd(12'd0, 5'd2, 8'd63, 1'b1);
        drv_wprot = 1;
        do_check();
        ck_eq("R4 wprot on first", chk_err, 4'b0010);
        drv_wprot = 0;
        do_check();
        ck_eq("R8 good after fail", addr_valid, 1);
        do_check();
        ck_eq("R8 later sector cyo", chk_err, 4'b1000);

        // R9 R10 R11 padding
        do_reset();
        pad_run(1'b1, 3, "R9 write short");
        pad_run(1'b0, 2, "R10 read short");
        pad_run(1'b1, 256, "R11 full write");
        pad_run(1'b0, 1, "R10 read single");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule